// File: doc/BRIEF.md
# Power-on Reset Sequencer

This block produces the internal chip reset. Three events can start a reset sequence. The first is the analog power-on detector, which drives the asynchronous `arst_n` pin. The second is a supply comparator that reports a voltage below the brown-out threshold. The third is a wake-up from sleep.

After a power-on or a brown-out, the block can hold reset through a power-up delay. That delay is counted on a slow RC-oscillator tick, which arrives as a one-cycle enable pulse in the main clock domain. After a power-on or a wake-up, and only when a crystal oscillator mode is selected, the block then waits an oscillator start-up delay counted in main clock cycles.

Brown-out dips shorter than a minimum number of RC ticks are filtered out. A longer dip holds reset for as long as the supply stays low. It also restarts the power-up delay from zero, even when the dip arrives while that delay is already running. Three sticky flags record which source last caused a reset, and software clears them with a single pulse.

Top module: `rst_sequencer`

## Requirements
- R1: While `arst_n` is low, `chip_rst` is 1, `st_por` is 1 and `st_bor`/`st_wake` are 0. After `arst_n` rises, the block waits two synchronizer clocks plus one state clock before starting its delays. With no delay enabled, `chip_rst` falls on the third rising clock edge.
- R2: With `cfg_pwrt_off`=0, the power-up delay keeps `chip_rst` high until `PWRT_TICKS` cycles with `rc_tick`=1 have been seen. Clock cycles without a tick do not advance it.
- R3: With `cfg_pwrt_off`=1, the power-up delay is skipped after both power-on and brown-out.
- R4: After a power-on, the start-up delay holds reset for a further `OST_CYCLES` clock cycles when `cfg_osc_mode` is a crystal mode (0, 1 or 2). Mode 3 (RC) skips it. This delay counts clocks, not ticks.
- R5: A brown-out is taken only after `bor_low` (after its two-flop synchronizer) has stayed 1 across `BOR_MIN_TICKS` RC ticks. A shorter dip changes nothing, and the filter count restarts after each dip.
- R6: Reset stays asserted for as long as a taken brown-out persists. Once `bor_low` returns to 0, the power-up delay runs and then reset is released with no start-up delay.
- R7: A brown-out taken while the power-up delay is counting restarts that delay from zero once the supply recovers.
- R8: With `cfg_bor_en`=0, `bor_low` has no effect on `chip_rst` or `st_bor`.
- R9: A one-cycle `wake` pulse while out of reset sets `st_wake`. In a crystal mode it also holds `chip_rst` high for `OST_CYCLES` clocks, starting at the next edge. In mode 3 it leaves `chip_rst` low.
- R10: The status flags stay set until a cycle with `flag_clr`=1 clears all three. A set event in that same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| arst_n | input | 1 | Power-on detector output, low = hold in reset (async) |
| rc_tick | input | 1 | One-cycle pulse per RC oscillator period |
| bor_low | input | 1 | Supply below brown-out threshold (async) |
| wake | input | 1 | Wake-up-from-sleep pulse |
| cfg_pwrt_off | input | 1 | 1 disables the power-up delay |
| cfg_bor_en | input | 1 | 1 enables brown-out detection |
| cfg_osc_mode | input | 2 | 0/1/2 crystal modes, 3 RC mode |
| flag_clr | input | 1 | Clears the status flags |
| chip_rst | output | 1 | Internal chip reset, active high |
| st_por | output | 1 | Last reset came from power-on |
| st_bor | output | 1 | A brown-out reset occurred |
| st_wake | output | 1 | A wake-up occurred |

## Verification
The bench sweeps all sixteen combinations of oscillator mode, power-up enable and brown-out enable. In each, it measures the exact number of clocks from power-on release to reset release, so a design that ran a skipped delay or mixed up the two time bases shows a wrong count.

It sends two dips that are each one tick short of the filter length, back to back. A filter that did not restart its count would trip on the second dip. It injects a brown-out partway through the power-up delay, and a design that resumed the old count would release reset several ticks early.

It also checks that a brown-out recovery never runs the start-up delay, and that a wake-up in RC mode never pulses reset.

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int PWRT_TICKS    = 72,
  parameter int OST_CYCLES    = 1024,
  parameter int BOR_MIN_TICKS = 4
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       rc_tick,
  input  logic       bor_low,
  input  logic       wake,
  input  logic       cfg_pwrt_off,
  input  logic       cfg_bor_en,
  input  logic [1:0] cfg_osc_mode,
  input  logic       flag_clr,
  output logic       chip_rst,
  output logic       st_por,
  output logic       st_bor,
  output logic       st_wake
);
  localparam int CMAX = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BW   = $clog2(BOR_MIN_TICKS + 1);
  localparam logic [CW-1:0] P_LAST = CW'(PWRT_TICKS - 1);
  localparam logic [CW-1:0] O_LAST = CW'(OST_CYCLES - 1);
  localparam logic [BW-1:0] B_FULL = BW'(BOR_MIN_TICKS);

  typedef enum logic [2:0] {
    S_INIT = 3'd0, S_PWRT = 3'd1, S_OST = 3'd2, S_RUN = 3'd3, S_BOR = 3'd4
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bor_cnt;
  logic [1:0]    por_sync, bor_sync;
  logic          after_por;

  wire bor_s   = bor_sync[1];
  wire xtal    = (cfg_osc_mode != 2'd3);
  wire bor_hit = cfg_bor_en && bor_s && (bor_cnt == B_FULL);

  assign chip_rst = (st != S_RUN);

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      por_sync <= 2'b00;
      bor_sync <= 2'b00;
    end else begin
      por_sync <= {por_sync[0], 1'b1};
      bor_sync <= {bor_sync[0], bor_low};
    end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)                    bor_cnt <= '0;
    else if (!bor_s || !cfg_bor_en) bor_cnt <= '0;
    else if (rc_tick && bor_cnt != B_FULL) bor_cnt <= bor_cnt + 1'b1;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      st        <= S_INIT;
      cnt       <= '0;
      after_por <= 1'b1;
    end else if (bor_hit) begin
      st  <= S_BOR;
      cnt <= '0;
    end else begin
      case (st)
        S_INIT:
          if (por_sync[1]) begin
            after_por <= 1'b1;
            st <= !cfg_pwrt_off ? S_PWRT : (xtal ? S_OST : S_RUN);
          end
        S_PWRT:
          if (rc_tick) begin
            if (cnt == P_LAST) begin
              cnt <= '0;
              st  <= (after_por && xtal) ? S_OST : S_RUN;
            end else cnt <= cnt + 1'b1;
          end
        S_OST:
          if (cnt == O_LAST) begin
            cnt <= '0;
            st  <= S_RUN;
          end else cnt <= cnt + 1'b1;
        S_RUN:
          if (wake && xtal) begin
            cnt <= '0;
            st  <= S_OST;
          end
        S_BOR: begin
          after_por <= 1'b0;
          cnt <= '0;
          st  <= cfg_pwrt_off ? S_RUN : S_PWRT;
        end
        default: st <= S_INIT;
      endcase
    end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      st_por  <= 1'b1;
      st_bor  <= 1'b0;
      st_wake <= 1'b0;
    end else begin
      if (flag_clr) begin
        st_por  <= 1'b0;
        st_bor  <= 1'b0;
        st_wake <= 1'b0;
      end
      if (bor_hit && st != S_BOR)              st_bor  <= 1'b1;
      if (!bor_hit && st == S_RUN && wake)     st_wake <= 1'b1;
    end
endmodule

module rst_sequencer_chk (
  input logic       clk,
  input logic       arst_n,
  input logic       rc_tick,
  input logic       wake,
  input logic       flag_clr,
  input logic       cfg_bor_en,
  input logic [1:0] cfg_osc_mode,
  input logic       st_bor,
  input logic       st_wake,
  input logic [2:0] st,
  input logic       bor_hit
);
  localparam logic [2:0] K_PWRT = 3'd1, K_OST = 3'd2, K_RUN = 3'd3, K_BOR = 3'd4;

  a_r2_pwrt_waits_tick: assert property (@(posedge clk) disable iff (!arst_n)
    (st == K_PWRT && !rc_tick) |=> (st == K_PWRT || st == K_BOR));

  a_r4_ost_xtal_only: assert property (@(posedge clk) disable iff (!arst_n)
    (st == K_OST) |-> (cfg_osc_mode != 2'd3));

  a_r5_bor_entry_filtered: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(st == K_BOR) |-> $past(bor_hit));

  a_r6_bor_holds: assert property (@(posedge clk) disable iff (!arst_n)
    (st == K_BOR && bor_hit) |=> (st == K_BOR));

  a_r8_bor_off: assert property (@(posedge clk) disable iff (!arst_n)
    !cfg_bor_en |=> !$rose(st_bor));

  a_r9_wake_flag: assert property (@(posedge clk) disable iff (!arst_n)
    (wake && st == K_RUN && !bor_hit) |=> st_wake);

  a_r10_bor_flag_sticky: assert property (@(posedge clk) disable iff (!arst_n)
    (st_bor && !flag_clr) |=> st_bor);
endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
  .clk(clk), .arst_n(arst_n), .rc_tick(rc_tick), .wake(wake),
  .flag_clr(flag_clr), .cfg_bor_en(cfg_bor_en), .cfg_osc_mode(cfg_osc_mode),
  .st_bor(st_bor), .st_wake(st_wake), .st(st), .bor_hit(bor_hit)
);

// File: tb/rst_sequencer_test.sv
module rst_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int P = 8;
  localparam int O = 16;
  localparam int B = 3;

  logic clk = 0, arst_n = 0, rc_tick = 0, bor_low = 0, wake = 0;
  logic cfg_pwrt_off = 0, cfg_bor_en = 1, flag_clr = 0;
  logic [1:0] cfg_osc_mode = 2'd1;
  logic chip_rst, st_por, st_bor, st_wake;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_sequencer #(.PWRT_TICKS(P), .OST_CYCLES(O), .BOR_MIN_TICKS(B)) uut (
    .clk(clk), .arst_n(arst_n), .rc_tick(rc_tick), .bor_low(bor_low), .wake(wake),
    .cfg_pwrt_off(cfg_pwrt_off), .cfg_bor_en(cfg_bor_en), .cfg_osc_mode(cfg_osc_mode),
    .flag_clr(flag_clr), .chip_rst(chip_rst), .st_por(st_por), .st_bor(st_bor),
    .st_wake(st_wake));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic clk_n(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic tick();
    rc_tick = 1; clk_n(1); rc_tick = 0;
  endtask

  task automatic ticks(int n);
    repeat (n) tick();
  endtask

  task automatic clear_flags();
    flag_clr = 1; clk_n(1); flag_clr = 0;
  endtask

  task automatic power_on(logic [1:0] mode, logic pw_off, logic ben);
    arst_n = 0; cfg_osc_mode = mode; cfg_pwrt_off = pw_off; cfg_bor_en = ben;
    clk_n(2);
    arst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1..R4 sweep: measure clocks from release to reset drop, tick every clock
    for (int m = 0; m < 4; m++)
      for (int pw = 0; pw < 2; pw++)
        for (int be = 0; be < 2; be++) begin
          int n, exp_n;
          arst_n = 0; cfg_osc_mode = 2'(m); cfg_pwrt_off = pw[0]; cfg_bor_en = be[0];
          clk_n(2);
          chk("R1 rst in reset", chip_rst, 1);
          chk("R1 por flag", st_por, 1);
          chk("R1 bor flag", st_bor, 0);
          chk("R1 wake flag", st_wake, 0);
          rc_tick = 1;
          arst_n = 1;
          n = 0;
          do begin clk_n(1); n++; end while (chip_rst && n < 200);
          rc_tick = 0;
          exp_n = 3 + (pw == 0 ? P : 0) + (m != 3 ? O : 0);
          chk("R2/R3/R4 reset length", n, exp_n);
          chk("R1 por flag after", st_por, 1);
        end

    // R2, R4: sparse ticks; power-up counts ticks, start-up counts clocks
    power_on(2'd1, 0, 1);
    clk_n(3);
    repeat (P - 1) begin tick(); clk_n(4); end
    clk_n(50);
    chk("R2 held without ticks", chip_rst, 1);
    tick();
    chk("R4 start-up begun", chip_rst, 1);
    clk_n(O - 1);
    chk("R4 held one clock short", chip_rst, 1);
    clk_n(1);
    chk("R4 released after start-up", chip_rst, 0);

    // R10 clear
    clear_flags();
    chk("R10 por cleared", st_por, 0);
    chk("R10 bor cleared", st_bor, 0);
    chk("R10 wake cleared", st_wake, 0);

    // R5 short dips, twice, counter must restart
    bor_low = 1; clk_n(2); ticks(B - 1);
    chk("R5 short dip ignored", chip_rst, 0);
    bor_low = 0; clk_n(3);
    bor_low = 1; clk_n(2); ticks(B - 1);
    chk("R5 second short dip ignored", chip_rst, 0);
    chk("R5 no bor flag", st_bor, 0);
    bor_low = 0; clk_n(3);

    // R5/R6 real brown-out, held, then power-up only
    bor_low = 1; clk_n(2); ticks(B);
    chk("R5 not yet taken", chip_rst, 0);
    clk_n(1);
    chk("R5 brown-out taken", chip_rst, 1);
    chk("R10 bor flag set", st_bor, 1);
    ticks(20); clk_n(30);
    chk("R6 held while low", chip_rst, 1);
    bor_low = 0; clk_n(3);
    ticks(P - 1);
    chk("R6 power-up running", chip_rst, 1);
    tick();
    chk("R6 released without start-up", chip_rst, 0);
    chk("R10 bor flag sticky", st_bor, 1);

    // R7 dip during power-up restarts it
    bor_low = 1; clk_n(2); ticks(B); clk_n(1);
    bor_low = 0; clk_n(3);
    ticks(2);
    bor_low = 1; clk_n(2); ticks(B); clk_n(1);
    chk("R7 back in brown-out", chip_rst, 1);
    bor_low = 0; clk_n(3);
    ticks(P - 1);
    chk("R7 power-up restarted from zero", chip_rst, 1);
    tick();
    chk("R7 released after full delay", chip_rst, 0);

    // R3 brown-out with power-up disabled
    cfg_pwrt_off = 1;
    bor_low = 1; clk_n(2); ticks(B); clk_n(1);
    chk("R3 brown-out taken", chip_rst, 1);
    bor_low = 0; clk_n(3);
    chk("R3 released immediately", chip_rst, 0);
    cfg_pwrt_off = 0;

    // R8 brown-out disabled
    clear_flags();
    cfg_bor_en = 0;
    bor_low = 1; clk_n(2); ticks(10); clk_n(2);
    chk("R8 no reset when disabled", chip_rst, 0);
    chk("R8 no flag when disabled", st_bor, 0);
    bor_low = 0; clk_n(3);
    cfg_bor_en = 1;

    // R9 wake in crystal mode
    wake = 1; clk_n(1); wake = 0;
    chk("R9 wake holds reset", chip_rst, 1);
    chk("R9 wake flag", st_wake, 1);
    clk_n(O - 1);
    chk("R9 held one clock short", chip_rst, 1);
    clk_n(1);
    chk("R9 released after start-up", chip_rst, 0);

    // R9 wake in RC mode; R10 set wins over clear
    cfg_osc_mode = 2'd3;
    clear_flags();
    wake = 1; flag_clr = 1; clk_n(1); wake = 0; flag_clr = 0;
    chk("R9 RC wake no reset", chip_rst, 0);
    chk("R10 set beats clear", st_wake, 1);
    clk_n(3);
    chk("R9 RC stays running", chip_rst, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule